// File: doc/BRIEF.md
# Seconds Timekeeper with Alarm

This block keeps wall-clock time in whole seconds for a chip's always-on domain. A 16-bit prescaler counts single-cycle tick enables, one per period of a 32.768 kHz reference. Each time the prescaler crosses a whole second, a 32-bit seconds register advances. A 32-bit alarm register is compared against the seconds value at that moment. The block has one clock: the slow reference arrives as a one-cycle enable pulse in the bus clock domain.

Software reaches the block through a single-cycle write port and a combinational read port. The block starts in the time-invalid state. While time is invalid or has overflowed, both counters stand still and read back as zero. To bring the clock into service, software stops the counter, loads the seconds register, and starts the counter again. Loading the seconds register is the only action that makes time valid again.

Three level interrupts follow their flags through per-source enables. A separate enabled pulse marks each new second.

Register map (3-bit address, 32-bit data):
- 0: seconds
- 1: prescaler
- 2: alarm
- 3: status
  - bit 0: invalid (read-only)
  - bit 1: overflow (read-only)
  - bit 2: alarm (read-only)
  - bit 4: counter enable (read/write)
- 4: control. Writing 1 to bit 0 performs a software reset. The register reads as 0.
- 5: interrupt enable
  - bit 0: invalid
  - bit 1: overflow
  - bit 2: alarm
  - bit 4: seconds pulse

Top module: `sec_timekeeper`

## Requirements
- R1: After reset, status reads 0x1 (invalid set, overflow, alarm and enable clear), interrupt enable reads 0x7, `irq_invalid` is high, and `irq_overflow`, `irq_alarm` and `sec_pulse` are low.
- R2: While the counter runs (enable set, invalid and overflow clear), the prescaler advances by one on each cycle with `tick_en` high. It holds without a tick, and it holds while the counter is disabled.
- R3: The seconds register increments when prescaler bit 14 changes from 1 to 0. In that same cycle, `sec_pulse` is high for exactly one cycle, but only if interrupt-enable bit 4 is set.
- R4: While the counter is enabled, writes to the seconds and prescaler registers are ignored. While it is disabled, such writes load the value, and the value then holds.
- R5: While the invalid or overflow flag is set, the seconds and prescaler registers do not advance and read as zero.
- R6: A write to the seconds register while the counter is disabled clears both the invalid flag and the overflow flag.
- R7: When the running seconds register increments past 0xFFFFFFFF, the overflow flag is set.
- R8: The alarm flag is set when the alarm register equals the seconds value at the moment it increments. Any write to the alarm register clears the flag. If such a write happens in the same cycle as a match, the flag stays clear.
- R9: `irq_invalid`, `irq_overflow` and `irq_alarm` each equal their status flag ANDed with interrupt-enable bits 0, 1 and 2 respectively.
- R10: Writing 1 to control bit 0 returns every register and flag to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data (combinational) |
| irq_invalid | output | 1 | Time-invalid interrupt level |
| irq_overflow | output | 1 | Overflow interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |
| sec_pulse | output | 1 | One-cycle seconds pulse |

## Verification
The prescaler is preset just below a second boundary (0x7FFE and 0x7FFF). A roll-over then takes one or two ticks, and the ticks before the roll separate plain advancing from the seconds carry. The same roll is repeated under three conditions:
- with the seconds pulse enabled and then disabled;
- with the alarm equal and then unequal to the seconds value;
- with an alarm write landing in the carry cycle, which isolates the write-wins ordering.

Loading 0xFFFFFFFF and rolling once exercises the overflow path and the frozen, zero-reading state. Writes attempted while counting, ticks while disabled, and a prescaler load made while time is invalid (seen only after recovery) show that protected or frozen state really did hold.

// File: rtl/sk_pkg.sv
package sk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC  = 3'd0,
        A_PRE  = 3'd1,
        A_ALM  = 3'd2,
        A_STAT = 3'd3,
        A_CTRL = 3'd4,
        A_IEN  = 3'd5
    } reg_addr_e;

    // bit positions shared by status and interrupt-enable views
    localparam int B_INV = 0;
    localparam int B_OVF = 1;
    localparam int B_ALM = 2;
    localparam int B_EN  = 4;
    localparam int B_SEC = 4;
    localparam int B_SRST = 0;

    typedef struct packed {
        logic alm;
        logic ovf;
        logic inv;
    } flags_t;

    typedef struct packed {
        logic sec;
        logic alm;
        logic ovf;
        logic inv;
    } ien_t;

    localparam flags_t FLAGS_RST = '{alm: 1'b0, ovf: 1'b0, inv: 1'b1};
    localparam ien_t   IEN_RST   = '{sec: 1'b0, alm: 1'b1, ovf: 1'b1, inv: 1'b1};

    function automatic logic [DATA_W-1:0] pack_status(flags_t f, logic en);
        logic [DATA_W-1:0] r;
        r        = '0;
        r[B_INV] = f.inv;
        r[B_OVF] = f.ovf;
        r[B_ALM] = f.alm;
        r[B_EN]  = en;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ien(ien_t e);
        logic [DATA_W-1:0] r;
        r        = '0;
        r[B_INV] = e.inv;
        r[B_OVF] = e.ovf;
        r[B_ALM] = e.alm;
        r[B_SEC] = e.sec;
        return r;
    endfunction

    function automatic ien_t unpack_ien(logic [DATA_W-1:0] d);
        ien_t e;
        e.inv = d[B_INV];
        e.ovf = d[B_OVF];
        e.alm = d[B_ALM];
        e.sec = d[B_SEC];
        return e;
    endfunction

endpackage

// File: rtl/sk_prescaler.sv
module sk_prescaler #(
    parameter int PRE_W     = 16,
    parameter int CARRY_BIT = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             ld,
    input  logic [PRE_W-1:0] ld_val,
    output logic [PRE_W-1:0] q,
    output logic             carry
);

    logic [PRE_W-1:0] nxt;

    assign nxt   = q + 1'b1;
    // second boundary: the carry bit falls as the count advances
    assign carry = run && tick && q[CARRY_BIT] && !nxt[CARRY_BIT];

    always_ff @(posedge clk) begin
        if (rst)             q <= '0;
        else if (ld)         q <= ld_val;
        else if (run && tick) q <= nxt;
    end

    // R2: nothing moves the count without a tick or a load
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(q));

    // R3: after a carry the watched bit has gone low
    p_carry_fall_r3: assert property (@(posedge clk) disable iff (rst)
        carry |=> !q[CARRY_BIT]);

endmodule

// File: rtl/sk_seconds.sv
module sk_seconds #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             ld,
    input  logic [SEC_W-1:0] ld_val,
    output logic [SEC_W-1:0] q,
    output logic             wrap
);

    assign wrap = inc && (&q);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + 1'b1;
    end

    // R4: an accepted load lands exactly
    p_load_exact_r4: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(ld_val)));

    // R3: an increment advances by one
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld) |=> (q == $past(q) + 1'b1));

endmodule

// File: rtl/sk_status.sv
module sk_status
    import sk_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             sec_ld,
    input  logic             wrap,
    input  logic             carry,
    input  logic [SEC_W-1:0] sec_now,
    input  logic             alm_wr,
    input  logic [SEC_W-1:0] alm_val,
    input  logic             ien_wr,
    input  ien_t             ien_val,
    output flags_t           flags,
    output logic             en,
    output logic [SEC_W-1:0] alarm,
    output ien_t             ien
);

    logic match;

    // compare uses the seconds value before the increment
    assign match = carry && (alarm == sec_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_RST;
            en    <= 1'b0;
            alarm <= '0;
            ien   <= IEN_RST;
        end else begin
            if (en_wr)  en  <= en_val;
            if (ien_wr) ien <= ien_val;
            if (alm_wr) alarm <= alm_val;

            if (sec_ld) flags.inv <= 1'b0;

            if (sec_ld)    flags.ovf <= 1'b0;
            else if (wrap) flags.ovf <= 1'b1;

            // software write takes priority over a same-cycle match
            if (alm_wr)     flags.alm <= 1'b0;
            else if (match) flags.alm <= 1'b1;
        end
    end

    // R7: a wrap always leaves overflow raised
    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flags.ovf);

    // R8: alarm write leaves the flag clear
    p_alarm_clear_r8: assert property (@(posedge clk) disable iff (rst)
        alm_wr |=> !flags.alm);

    // R6: loading seconds makes time valid
    p_load_valid_r6: assert property (@(posedge clk) disable iff (rst)
        sec_ld |=> (!flags.inv && !flags.ovf));

    // R1: the invalid flag is only ever cleared by a seconds load
    p_inv_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        (flags.inv && !sec_ld) |=> flags.inv);

endmodule

// File: rtl/sec_timekeeper.sv
module sec_timekeeper
    import sk_pkg::*;
#(
    parameter int PRE_W     = 16,
    parameter int CARRY_BIT = 14,
    parameter int SEC_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_invalid,
    output logic              irq_overflow,
    output logic              irq_alarm,
    output logic              sec_pulse
);

    localparam int PRE_PAD = DATA_W - PRE_W;
    localparam int SEC_PAD = DATA_W - SEC_W;

    logic             srst, rst_all;
    logic             en, run, frozen, carry, wrap;
    logic             sec_ld, pre_ld, alm_wr, en_wr, ien_wr;
    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q, alarm_q;
    flags_t           flags;
    ien_t             ien;
    logic             pulse_q;

    // write decode
    assign srst    = wr_en && (wr_addr == A_CTRL) && wr_data[B_SRST];
    assign rst_all = rst || srst;
    assign sec_ld  = wr_en && (wr_addr == A_SEC) && !en;
    assign pre_ld  = wr_en && (wr_addr == A_PRE) && !en;
    assign alm_wr  = wr_en && (wr_addr == A_ALM);
    assign en_wr   = wr_en && (wr_addr == A_STAT);
    assign ien_wr  = wr_en && (wr_addr == A_IEN);

    assign frozen = flags.inv || flags.ovf;
    assign run    = en && !frozen;

    sk_prescaler #(.PRE_W(PRE_W), .CARRY_BIT(CARRY_BIT)) u_pre (
        .clk    (clk),
        .rst    (rst_all),
        .run    (run),
        .tick   (tick_en),
        .ld     (pre_ld),
        .ld_val (wr_data[PRE_W-1:0]),
        .q      (pre_q),
        .carry  (carry)
    );

    sk_seconds #(.SEC_W(SEC_W)) u_sec (
        .clk    (clk),
        .rst    (rst_all),
        .inc    (carry),
        .ld     (sec_ld),
        .ld_val (wr_data[SEC_W-1:0]),
        .q      (sec_q),
        .wrap   (wrap)
    );

    sk_status #(.SEC_W(SEC_W)) u_stat (
        .clk     (clk),
        .rst     (rst_all),
        .en_wr   (en_wr),
        .en_val  (wr_data[B_EN]),
        .sec_ld  (sec_ld),
        .wrap    (wrap),
        .carry   (carry),
        .sec_now (sec_q),
        .alm_wr  (alm_wr),
        .alm_val (wr_data[SEC_W-1:0]),
        .ien_wr  (ien_wr),
        .ien_val (unpack_ien(wr_data)),
        .flags   (flags),
        .en      (en),
        .alarm   (alarm_q),
        .ien     (ien)
    );

    // seconds pulse, registered alongside the seconds increment
    always_ff @(posedge clk) begin
        if (rst_all) pulse_q <= 1'b0;
        else         pulse_q <= carry && ien.sec;
    end

    assign sec_pulse    = pulse_q;
    assign irq_invalid  = flags.inv && ien.inv;
    assign irq_overflow = flags.ovf && ien.ovf;
    assign irq_alarm    = flags.alm && ien.alm;

    // read mux: counters read as zero while time is not trustworthy
    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = frozen ? '0 : {{SEC_PAD{1'b0}}, sec_q};
            A_PRE:   rd_data = frozen ? '0 : {{PRE_PAD{1'b0}}, pre_q};
            A_ALM:   rd_data = {{SEC_PAD{1'b0}}, alarm_q};
            A_STAT:  rd_data = pack_status(flags, en);
            A_IEN:   rd_data = pack_ien(ien);
            default: rd_data = '0;
        endcase
    end

    // R3: the seconds pulse never lasts two cycles
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst_all)
        sec_pulse |=> !sec_pulse);

    // R4: a seconds write while counting leaves the register alone
    p_locked_write_r4: assert property (@(posedge clk) disable iff (rst_all)
        (wr_en && (wr_addr == A_SEC) && en && !carry) |=> $stable(sec_q));

    // R5: frozen time does not advance
    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (rst_all)
        (frozen && !sec_ld && !pre_ld) |=> ($stable(sec_q) && $stable(pre_q)));

endmodule

// File: tb/sec_timekeeper_tb.sv
module sec_timekeeper_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq_invalid, irq_overflow, irq_alarm, sec_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sec_timekeeper u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .irq_invalid  (irq_invalid),
        .irq_overflow (irq_overflow),
        .irq_alarm    (irq_alarm),
        .sec_pulse    (sec_pulse)
    );

    localparam logic [2:0] SEC = 0, PRE = 1, ALM = 2, STAT = 3, CTRL = 4, IEN = 5;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(STAT, d); chk("R1 status after reset", d, 32'h1);
        rd(IEN, d);  chk("R1 irq enable after reset", d, 32'h7);
        chk("R1 irq lines", {28'h0, irq_invalid, irq_overflow, irq_alarm, sec_pulse}, 32'h8);
        rd(SEC, d);  chk("R5 seconds reads zero while invalid", d, 0);
    endtask

    task automatic t_frozen();
        logic [31:0] d;
        wr(PRE, 32'h0100);
        rd(PRE, d); chk("R5 prescaler reads zero while invalid", d, 0);
        wr(STAT, 32'h10);
        repeat (3) tick();
        wr(STAT, 32'h0);
        wr(SEC, 32'd100);
        rd(STAT, d); chk("R6 flags cleared by seconds load", d, 0);
        chk("R9 invalid irq drops with flag", {31'h0, irq_invalid}, 0);
        rd(PRE, d); chk("R5 prescaler held while invalid", d, 32'h0100);
        rd(SEC, d); chk("R4 seconds loaded while disabled", d, 32'd100);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        wr(PRE, 32'h7FFE);
        wr(STAT, 32'h10);
        wr(SEC, 32'd5);
        wr(PRE, 32'h0);
        rd(SEC, d); chk("R4 seconds write ignored while enabled", d, 32'd100);
        rd(PRE, d); chk("R4 prescaler write ignored while enabled", d, 32'h7FFE);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(IEN, 32'h17);
        tick();
        rd(PRE, d); chk("R2 prescaler advances per tick", d, 32'h7FFF);
        rd(SEC, d); chk("R3 no second before bit 14 falls", d, 32'd100);
        chk("R3 no pulse before carry", {31'h0, sec_pulse}, 0);
        tick();
        chk("R3 pulse on second", {31'h0, sec_pulse}, 1);
        rd(SEC, d); chk("R3 seconds increments", d, 32'd101);
        @(negedge clk); #1;
        chk("R3 pulse lasts one cycle", {31'h0, sec_pulse}, 0);
        repeat (3) @(negedge clk);
        #1;
        rd(PRE, d); chk("R2 prescaler holds without tick", d, 32'h8000);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr(STAT, 32'h0);
        wr(PRE, 32'h7FFF);
        tick();
        rd(PRE, d); chk("R2 prescaler holds while disabled", d, 32'h7FFF);
        wr(IEN, 32'h07);
        wr(STAT, 32'h10);
        tick();
        chk("R3 pulse masked by enable", {31'h0, sec_pulse}, 0);
        rd(SEC, d); chk("R3 second counted with pulse masked", d, 32'd102);
    endtask

    task automatic t_alarm();
        logic [31:0] d;
        wr(STAT, 32'h0);
        wr(SEC, 32'd200);
        wr(ALM, 32'd200);
        wr(PRE, 32'h7FFF);
        wr(STAT, 32'h10);
        tick();
        rd(STAT, d); chk("R8 alarm flag on match", d, 32'h14);
        chk("R9 alarm irq follows flag", {31'h0, irq_alarm}, 1);
        wr(ALM, 32'd0);
        rd(STAT, d); chk("R8 alarm write clears flag", d, 32'h10);
        // no match: alarm far away
        wr(STAT, 32'h0);
        wr(SEC, 32'd300);
        wr(ALM, 32'd500);
        wr(PRE, 32'h7FFF);
        wr(STAT, 32'h10);
        tick();
        rd(STAT, d); chk("R8 no flag without match", d, 32'h10);
        // same-cycle alarm write and match
        wr(STAT, 32'h0);
        wr(SEC, 32'd400);
        wr(ALM, 32'd400);
        wr(PRE, 32'h7FFF);
        wr(STAT, 32'h10);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_addr = ALM; wr_data = 32'd400;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        #1;
        rd(STAT, d); chk("R8 write wins over match", d, 32'h10);
        rd(SEC, d);  chk("R8 second still counted on collision", d, 32'd401);
        // masked alarm irq
        wr(STAT, 32'h0);
        wr(SEC, 32'd600);
        wr(ALM, 32'd600);
        wr(PRE, 32'h7FFF);
        wr(IEN, 32'h03);
        wr(STAT, 32'h10);
        tick();
        rd(STAT, d); chk("R8 flag set with irq masked", d, 32'h14);
        chk("R9 alarm irq masked", {31'h0, irq_alarm}, 0);
        wr(ALM, 32'd0);
        wr(IEN, 32'h07);
    endtask

    task automatic t_ovf();
        logic [31:0] d;
        wr(STAT, 32'h0);
        wr(SEC, 32'hFFFF_FFFF);
        wr(PRE, 32'h7FFF);
        wr(STAT, 32'h10);
        tick();
        rd(STAT, d); chk("R7 overflow flag on wrap", d, 32'h12);
        chk("R9 overflow irq", {31'h0, irq_overflow}, 1);
        repeat (4) tick();
        rd(SEC, d); chk("R5 seconds zero after overflow", d, 0);
        rd(PRE, d); chk("R5 prescaler zero after overflow", d, 0);
        wr(STAT, 32'h0);
        wr(SEC, 32'd7);
        rd(STAT, d); chk("R6 overflow cleared by load", d, 0);
        rd(PRE, d);  chk("R5 prescaler froze at wrap", d, 32'h8000);
        chk("R9 overflow irq drops", {31'h0, irq_overflow}, 0);
    endtask

    task automatic t_srst();
        logic [31:0] d;
        wr(IEN, 32'h10);
        wr(ALM, 32'd9);
        wr(CTRL, 32'h1);
        rd(STAT, d); chk("R10 status after soft reset", d, 32'h1);
        rd(IEN, d);  chk("R10 irq enable after soft reset", d, 32'h7);
        rd(ALM, d);  chk("R10 alarm after soft reset", d, 0);
        chk("R10 invalid irq after soft reset", {31'h0, irq_invalid}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_frozen();
        t_protect();
        t_count();
        t_gate();
        t_alarm();
        t_ovf();
        t_srst();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule